// File: doc/BRIEF.md
# I/O Port Access Router with Configuration Address Register

The block sits behind the I/O port decode of a core and decides where each I/O port access goes. Each request carries a port number, an access size in bytes, a write flag and write data. One cycle later the block answers with a target kind and a physical address for the fabric. The requester then completes the access.

Three destinations exist. The first is an internal 32-bit configuration-address register, reached at port 0xCF8 by 4-byte accesses only. The second is the PCI configuration space, reached through the four-port data window 0xCFC..0xCFF, and only while the register's enable bit (bit 31) is set. Every other legal port goes to the plain I/O space. The configuration-space and I/O-space address prefixes are parameters. They sit above bit 32 of the physical address, so neither space can alias ordinary memory. A port number with any bit set above bit 15 is rejected with an error kind.

Top module: `io_cfg_mapper`

## Requirements
- R1: A request with `req_valid_i` high produces `rsp_valid_o` high on the next clock edge, and a cycle without a request produces `rsp_valid_o` low. `rsp_valid_o` is low during and after reset.
- R2: A request whose port has any bit set above bit 15 returns kind 4 (error) and address 0, and leaves the configuration-address register unchanged even when its low 16 bits are 0x0CF8.
- R3: Port 0x0CF8 with `size_i` equal to 3'd4 (size is a byte count) returns kind 1 (register). A write loads `wdata_i` into the register at the response edge. A read returns the register's current value on `rdata_o`. The register resets to 0.
- R4: For ports 0x0CFC..0x0CFF while register bit 31 is 1, the block returns kind 2 (configuration space). The address is `CFG_PREFIX` OR register bits 30:2 in place OR port bits 1:0. Register bits 31, 1 and 0 do not appear in the address.
- R5: For ports 0x0CFC..0x0CFF while register bit 31 is 0, the block returns kind 0 (no target) with address 0. A read of this kind returns all ones on `rdata_o`.
- R6: Every other port with the upper bits clear returns kind 3 (I/O space) with address `IO_PREFIX` OR the 16-bit port. This includes 0x0CF8 with a size other than 4, 0x0CFB and 0x0D00.
- R7: No write other than a 4-byte write to port 0x0CF8 changes the configuration-address register. This covers writes to the data window, to 0x0CF8 with other sizes, and to other ports.
- R8: `rdata_o` is 0 on every response except a register read (R3) and a no-target read (R5).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe |
| port_i | input | PORT_W (32) | Port number; only bits 15:0 are legal |
| size_i | input | SIZE_W (3) | Access size in bytes |
| write_i | input | 1 | 1 for write, 0 for read |
| wdata_i | input | DATA_W (32) | Write data |
| rsp_valid_o | output | 1 | Response valid, one cycle after the request |
| kind_o | output | 3 | Target kind: 0 none, 1 register, 2 config space, 3 I/O space, 4 error |
| paddr_o | output | ADDR_W (40) | Physical address of the target |
| rdata_o | output | DATA_W (32) | Register read data, or all ones for a no-target read |

## Verification
The assertions assume that requests come no faster than one per clock and that each request's fields are steady around the rising edge. They also assume `size_i` is a byte count, so the register update is keyed on the exact value 4. The bench drives every field at the falling edge and holds it for a full cycle. It uses only the sizes 1, 2 and 4. It tests out-of-range ports only through explicitly set upper bits, so an error response never depends on an undriven value.

// File: rtl/io_map_pkg.sv
package io_map_pkg;
  typedef enum logic [2:0] {
    TGT_NONE      = 3'd0,
    TGT_CFG_REG   = 3'd1,
    TGT_CFG_SPACE = 3'd2,
    TGT_IO        = 3'd3,
    TGT_ERR       = 3'd4
  } tgt_kind_e;

  localparam logic [15:0] CFG_ADDR_PORT = 16'h0CF8;
  localparam logic [15:0] CFG_DATA_BASE = 16'h0CFC;
  localparam int unsigned CFG_REG_BYTES = 4;
endpackage

// File: rtl/io_port_classify.sv
module io_port_classify
  import io_map_pkg::*;
#(
  parameter int unsigned PORT_W    = 32,
  parameter int unsigned PORT_BITS = 16,
  parameter int unsigned SIZE_W    = 3
) (
  input  logic [PORT_W-1:0] port_i,
  input  logic [SIZE_W-1:0] size_i,
  output logic              out_of_range_o,
  output logic              hit_cfg_reg_o,
  output logic              hit_window_o
);
  localparam logic [PORT_BITS-1:0] ADDR_PORT = PORT_BITS'(CFG_ADDR_PORT);
  localparam logic [PORT_BITS-1:0] WIN_BASE  = PORT_BITS'(CFG_DATA_BASE);

  logic [PORT_BITS-1:0] low_port;

  assign low_port       = port_i[PORT_BITS-1:0];
  assign out_of_range_o = |port_i[PORT_W-1:PORT_BITS];
  assign hit_cfg_reg_o  = !out_of_range_o && (low_port == ADDR_PORT)
                          && (size_i == SIZE_W'(CFG_REG_BYTES));
  assign hit_window_o   = !out_of_range_o
                          && ({low_port[PORT_BITS-1:2], 2'b00} == WIN_BASE);
endmodule

// File: rtl/io_cfg_addr_reg.sv
module io_cfg_addr_reg #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] value_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     value_o <= '0;
    else if (load_i) value_o <= wdata_i;
  end
endmodule

// File: rtl/io_map_resp.sv
module io_map_resp
  import io_map_pkg::*;
#(
  parameter int unsigned PORT_BITS  = 16,
  parameter int unsigned ADDR_W     = 40,
  parameter int unsigned DATA_W     = 32,
  parameter logic [ADDR_W-1:0] IO_PREFIX  = 40'h10_0000_0000,
  parameter logic [ADDR_W-1:0] CFG_PREFIX = 40'h20_0000_0000
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_valid_i,
  input  logic                 write_i,
  input  logic [PORT_BITS-1:0] low_port_i,
  input  logic                 out_of_range_i,
  input  logic                 hit_cfg_reg_i,
  input  logic                 hit_window_i,
  input  logic [DATA_W-1:0]    cfg_addr_i,
  output logic                 rsp_valid_o,
  output tgt_kind_e            kind_o,
  output logic [ADDR_W-1:0]    paddr_o,
  output logic [DATA_W-1:0]    rdata_o
);
  localparam int unsigned EN_BIT = DATA_W - 1;

  tgt_kind_e         kind_d;
  logic [ADDR_W-1:0] paddr_d;
  logic [DATA_W-1:0] rdata_d;

  always_comb begin
    kind_d  = TGT_IO;
    paddr_d = IO_PREFIX | ADDR_W'(low_port_i);
    rdata_d = '0;
    if (out_of_range_i) begin
      kind_d  = TGT_ERR;
      paddr_d = '0;
    end else if (hit_cfg_reg_i) begin
      kind_d  = TGT_CFG_REG;
      paddr_d = '0;
      if (!write_i) rdata_d = cfg_addr_i;
    end else if (hit_window_i) begin
      if (cfg_addr_i[EN_BIT]) begin
        kind_d  = TGT_CFG_SPACE;
        // bits 1:0 of the register are replaced by the window offset
        paddr_d = CFG_PREFIX | ADDR_W'({cfg_addr_i[EN_BIT-1:2], low_port_i[1:0]});
      end else begin
        kind_d  = TGT_NONE;
        paddr_d = '0;
        if (!write_i) rdata_d = '1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      kind_o      <= TGT_NONE;
      paddr_o     <= '0;
      rdata_o     <= '0;
    end else begin
      rsp_valid_o <= req_valid_i;
      if (req_valid_i) begin
        kind_o  <= kind_d;
        paddr_o <= paddr_d;
        rdata_o <= rdata_d;
      end
    end
  end
endmodule

// File: rtl/io_cfg_mapper.sv
module io_cfg_mapper
  import io_map_pkg::*;
#(
  parameter int unsigned PORT_W    = 32,
  parameter int unsigned PORT_BITS = 16,
  parameter int unsigned SIZE_W    = 3,
  parameter int unsigned ADDR_W    = 40,
  parameter int unsigned DATA_W    = 32,
  parameter logic [ADDR_W-1:0] IO_PREFIX  = 40'h10_0000_0000,
  parameter logic [ADDR_W-1:0] CFG_PREFIX = 40'h20_0000_0000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [PORT_W-1:0] port_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic              write_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              rsp_valid_o,
  output logic [2:0]        kind_o,
  output logic [ADDR_W-1:0] paddr_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic              out_of_range;
  logic              hit_cfg_reg;
  logic              hit_window;
  logic              cfg_load;
  logic [DATA_W-1:0] cfg_addr_q;
  tgt_kind_e         kind_q;

  io_port_classify #(
    .PORT_W(PORT_W), .PORT_BITS(PORT_BITS), .SIZE_W(SIZE_W)
  ) u_classify (
    .port_i         (port_i),
    .size_i         (size_i),
    .out_of_range_o (out_of_range),
    .hit_cfg_reg_o  (hit_cfg_reg),
    .hit_window_o   (hit_window)
  );

  assign cfg_load = req_valid_i && write_i && hit_cfg_reg;

  io_cfg_addr_reg #(.DATA_W(DATA_W)) u_cfg_reg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (cfg_load),
    .wdata_i (wdata_i),
    .value_o (cfg_addr_q)
  );

  io_map_resp #(
    .PORT_BITS(PORT_BITS), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .IO_PREFIX(IO_PREFIX), .CFG_PREFIX(CFG_PREFIX)
  ) u_resp (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .req_valid_i    (req_valid_i),
    .write_i        (write_i),
    .low_port_i     (port_i[PORT_BITS-1:0]),
    .out_of_range_i (out_of_range),
    .hit_cfg_reg_i  (hit_cfg_reg),
    .hit_window_i   (hit_window),
    .cfg_addr_i     (cfg_addr_q),
    .rsp_valid_o    (rsp_valid_o),
    .kind_o         (kind_q),
    .paddr_o        (paddr_o),
    .rdata_o        (rdata_o)
  );

  assign kind_o = kind_q;
endmodule

// File: rtl/io_cfg_mapper_chk.sv
module io_cfg_mapper_chk
  import io_map_pkg::*;
#(
  parameter int unsigned PORT_W    = 32,
  parameter int unsigned PORT_BITS = 16,
  parameter int unsigned SIZE_W    = 3,
  parameter int unsigned ADDR_W    = 40,
  parameter int unsigned DATA_W    = 32,
  parameter logic [ADDR_W-1:0] CFG_PREFIX = 40'h20_0000_0000
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic [PORT_W-1:0] port_i,
  input logic [SIZE_W-1:0] size_i,
  input logic              write_i,
  input logic              rsp_valid_o,
  input logic [2:0]        kind_o,
  input logic [ADDR_W-1:0] paddr_o,
  input logic [DATA_W-1:0] rdata_o,
  input logic [DATA_W-1:0] cfg_addr_q
);
  logic reg_write;
  assign reg_write = req_valid_i && write_i && (port_i == PORT_W'(CFG_ADDR_PORT))
                     && (size_i == SIZE_W'(CFG_REG_BYTES));

  assert_rsp_follows_req_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);

  assert_no_rsp_when_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o);

  assert_high_bits_error_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && |port_i[PORT_W-1:PORT_BITS]) |=> (kind_o == 3'(TGT_ERR)) && (paddr_o == '0));

  assert_reg_holds_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_write |=> $stable(cfg_addr_q));

  assert_cfg_prefix_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && kind_o == 3'(TGT_CFG_SPACE)) |-> (paddr_o[ADDR_W-1:32] == CFG_PREFIX[ADDR_W-1:32]));

  assert_none_reads_ones_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !write_i && (port_i[PORT_W-1:2] == PORT_W'(CFG_DATA_BASE) >> 2)
     && !cfg_addr_q[DATA_W-1]) |=> (kind_o == 3'(TGT_NONE)) && (rdata_o == '1));
endmodule

bind io_cfg_mapper io_cfg_mapper_chk #(
  .PORT_W(PORT_W), .PORT_BITS(PORT_BITS), .SIZE_W(SIZE_W),
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CFG_PREFIX(CFG_PREFIX)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .port_i      (port_i),
  .size_i      (size_i),
  .write_i     (write_i),
  .rsp_valid_o (rsp_valid_o),
  .kind_o      (kind_o),
  .paddr_o     (paddr_o),
  .rdata_o     (rdata_o),
  .cfg_addr_q  (cfg_addr_q)
);

// File: tb/io_cfg_mapper_tb.sv
`timescale 1ns/1ps
module io_cfg_mapper_tb;
  typedef struct packed {
    logic [31:0] port;
    logic [2:0]  size;
    logic        wr;
    logic [31:0] wdata;
    logic [2:0]  kind;
    logic [39:0] paddr;
    logic [31:0] rdata;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 22;
  localparam int VW = $bits(vec_t);

  // port, size, wr, wdata, exp kind, exp paddr, exp rdata, requirement
  localparam logic [VW-1:0] VECS [NV] = '{
    {32'h0CF8, 3'd4, 1'b0, 32'h0,         3'd1, 40'h0,            32'h0,         4'd3}, // R3 reset value
    {32'h0CFC, 3'd4, 1'b0, 32'h0,         3'd0, 40'h0,            32'hFFFF_FFFF, 4'd5}, // R5
    {32'h0CF8, 3'd4, 1'b1, 32'h8000_1234, 3'd1, 40'h0,            32'h0,         4'd3}, // R3 write
    {32'h0CF8, 3'd4, 1'b0, 32'h0,         3'd1, 40'h0,            32'h8000_1234, 4'd3}, // R3 read back
    {32'h0CFC, 3'd4, 1'b0, 32'h0,         3'd2, 40'h20_0000_1234, 32'h0,         4'd4}, // R4
    {32'h0CFE, 3'd2, 1'b0, 32'h0,         3'd2, 40'h20_0000_1236, 32'h0,         4'd4}, // R4
    {32'h0CFF, 3'd1, 1'b1, 32'h55,        3'd2, 40'h20_0000_1237, 32'h0,         4'd8}, // R8
    {32'h0CF8, 3'd4, 1'b0, 32'h0,         3'd1, 40'h0,            32'h8000_1234, 4'd7}, // R7
    {32'h0CF8, 3'd2, 1'b1, 32'h0,         3'd3, 40'h10_0000_0CF8, 32'h0,         4'd6}, // R6
    {32'h0CF8, 3'd4, 1'b0, 32'h0,         3'd1, 40'h0,            32'h8000_1234, 4'd7}, // R7
    {32'h0CF8, 3'd4, 1'b1, 32'hFFFF_FFFF, 3'd1, 40'h0,            32'h0,         4'd3}, // R3
    {32'h0CFD, 3'd1, 1'b0, 32'h0,         3'd2, 40'h20_7FFF_FFFD, 32'h0,         4'd4}, // R4
    {32'h0080, 3'd1, 1'b0, 32'h0,         3'd3, 40'h10_0000_0080, 32'h0,         4'd6}, // R6
    {32'hFFFF, 3'd1, 1'b0, 32'h0,         3'd3, 40'h10_0000_FFFF, 32'h0,         4'd6}, // R6
    {32'h1_0CF8, 3'd4, 1'b1, 32'h0,       3'd4, 40'h0,            32'h0,         4'd2}, // R2
    {32'h0CF8, 3'd4, 1'b0, 32'h0,         3'd1, 40'h0,            32'hFFFF_FFFF, 4'd2}, // R2 no update
    {32'h0CF8, 3'd4, 1'b1, 32'h7FFF_FFFF, 3'd1, 40'h0,            32'h0,         4'd3}, // R3
    {32'h0CFC, 3'd4, 1'b0, 32'h0,         3'd0, 40'h0,            32'hFFFF_FFFF, 4'd5}, // R5
    {32'h0CFC, 3'd4, 1'b1, 32'h0,         3'd0, 40'h0,            32'h0,         4'd8}, // R8
    {32'h8000_0070, 3'd1, 1'b0, 32'h0,    3'd4, 40'h0,            32'h0,         4'd2}, // R2
    {32'h0CFB, 3'd4, 1'b0, 32'h0,         3'd3, 40'h10_0000_0CFB, 32'h0,         4'd6}, // R6
    {32'h0D00, 3'd4, 1'b0, 32'h0,         3'd3, 40'h10_0000_0D00, 32'h0,         4'd6}  // R6
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [31:0] port_i = '0;
  logic [2:0]  size_i = '0;
  logic        write_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic        rsp_valid_o;
  logic [2:0]  kind_o;
  logic [39:0] paddr_o;
  logic [31:0] rdata_o;

  int checks = 0;
  int errors = 0;

  always #2.5 clk_i = ~clk_i;

  io_cfg_mapper u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .port_i(port_i),
    .size_i(size_i), .write_i(write_i), .wdata_i(wdata_i), .rsp_valid_o(rsp_valid_o),
    .kind_o(kind_o), .paddr_o(paddr_o), .rdata_o(rdata_o)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [31:0] p, input logic [2:0] s, input logic w, input logic [31:0] d);
    req_valid_i = 1'b1; port_i = p; size_i = s; write_i = w; wdata_i = d;
  endtask

  initial begin
    #(5.0 * 5000);
    errors++;
    $display("FAIL R1 watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check("R1 reset rsp_valid", 64'(rsp_valid_o), 64'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 idle rsp_valid", 64'(rsp_valid_o), 64'd0);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = vec_t'(VECS[i]);
      drive(v.port, v.size, v.wr, v.wdata);
      @(negedge clk_i);
      check($sformatf("R%0d vec%0d valid", v.req, i), 64'(rsp_valid_o), 64'd1);
      check($sformatf("R%0d vec%0d kind", v.req, i), 64'(kind_o), 64'(v.kind));
      check($sformatf("R%0d vec%0d paddr", v.req, i), 64'(paddr_o), 64'(v.paddr));
      check($sformatf("R%0d vec%0d rdata", v.req, i), 64'(rdata_o), 64'(v.rdata));
    end

    // R1: dropping the strobe drops the response on the next edge
    req_valid_i = 1'b0;
    @(negedge clk_i);
    check("R1 no request", 64'(rsp_valid_o), 64'd0);

    // R7: window write with enable set must not alter the register
    drive(32'h0CF8, 3'd4, 1'b1, 32'h8000_00A8);
    @(negedge clk_i);
    drive(32'h0CFC, 3'd4, 1'b1, 32'h1111_1111);
    @(negedge clk_i);
    drive(32'h0CF8, 3'd4, 1'b0, 32'h0);
    @(negedge clk_i);
    check("R7 window write kept reg", 64'(rdata_o), 64'h8000_00A8);

    // R3: reset clears the register
    req_valid_i = 1'b0;
    rst_ni = 1'b0;
    @(negedge clk_i);
    check("R1 rsp_valid in reset", 64'(rsp_valid_o), 64'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    drive(32'h0CF8, 3'd4, 1'b0, 32'h0);
    @(negedge clk_i);
    check("R3 reg cleared by reset", 64'(rdata_o), 64'h0);
    drive(32'h0CFF, 3'd1, 1'b0, 32'h0);
    @(negedge clk_i);
    check("R5 window disabled after reset", 64'(kind_o), 64'd0);
    req_valid_i = 1'b0;
    @(negedge clk_i);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule